// File: doc/BRIEF.md
# Two-wire serial bus master (byte level)

This block is the controlling end of a two-wire serial bus with open-drain clock and data lines. It runs from a fast system clock. It never drives either line high. Each line has an enable output, and a 1 on that output pulls the line low; a 0 releases it to the pull-up. Both line levels come back in through inputs and pass through a two-flop synchroniser before any decision uses them.

The host gives one command at a time: START, WRITE (one byte out), READ (one byte in, with a choice of acknowledge or not-acknowledge on the ninth clock) and STOP. A START issued while a transfer is open is a repeated START, so a write-then-read sequence can be built without releasing the bus. Each byte command returns the eight bits sampled from the data line and the acknowledge seen on the ninth clock. The host forms the first byte after START itself: the 7-bit target address shifted left by one, with the direction bit in bit 0 (0 = write, 1 = read).

Every bit is split into four quarter periods. The `div_quarter` input sets each quarter in system-clock cycles, so one value gives the 100 kHz rate and another the 400 kHz rate. When a target holds the clock line low after it has been released, the block waits until the synchronised clock line reads high before it starts to time the high phase.

Command interface rules: the command is taken in the cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the cycle after acceptance until the command completes, and a valid command held during that time is neither taken nor lost. `done` is a one-cycle pulse at completion. `cmd_ready` rises in the same cycle. `rx_data` and `ack_received` are valid with `done` for byte commands and hold their values until the next byte command.

Top module: `i2cm_master`

## Requirements
- R1: After reset both line enables are 0 (both lines released), `cmd_ready` is 1 and `done` is 0. The block only ever pulls a line low through `scl_oe`/`sda_oe`.
- R2: START releases SDA while SCL is low, releases SCL, pulls SDA low while SCL is high, then pulls SCL low. The same command issued mid-transfer produces a repeated START.
- R3: Outside START and STOP, SDA changes only while the block holds SCL low, so the bus carries exactly one start event per START and one stop event per STOP.
- R4: WRITE sends 8 bits MSB first on 8 SCL pulses, then releases SDA for a 9th pulse. `ack_received` is 1 when SDA was sampled low there. `rx_data` holds the 8 sampled line bits.
- R5: READ releases SDA for 8 pulses and returns the bits MSB first in `rx_data`. On the 9th pulse SDA is pulled low when `cmd_nack` = 0 (acknowledge) and left high when `cmd_nack` = 1 (last byte).
- R6: STOP pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is high, leaving both lines released.
- R7: Without stretching, each SCL high phase lasts between 2·D and 2·D+4 system clocks and each low phase at least 2·D, where D = `div_quarter`.
- R8: While a target holds SCL low, the block neither advances nor times the high phase, and bits transfer unchanged.
- R9: A command is taken only when `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a command runs. `done` lasts exactly one cycle.
- R10: A not-acknowledge from the target gives `ack_received` = 0, and a following STOP or repeated START proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_quarter | input | DIV_W | Quarter-bit length in system clocks (held while busy) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | input | BYTE_W | Byte to send for WRITE |
| cmd_nack | input | 1 | READ only: 1 leaves SDA high on the 9th clock |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | BYTE_W | Bits sampled during the last byte command |
| ack_received | output | 1 | 1 when the 9th-clock sample was low |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The embedded assertions check four properties on every cycle. SDA never moves under a released SCL except inside START or STOP. The quarter index is frozen while a held-low clock line reads low. A taken command drops `cmd_ready` and `done` stays a single pulse. STOP completion leaves both lines released. Other behaviours only show up in the bench's scenarios against a behavioural target on the wired-AND lines: bit order, acknowledge sampling and the not-acknowledge on the last read byte. The same holds for the measured high and low phase widths over two divider settings and for the stretched clock with data still intact.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BYTE  = 2'd2,
    ST_STOP  = 2'd3
  } seq_st_e;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '1;
      else        ff <= {ff[STAGES-2:0], d[i]};
    end
    assign q[i] = ff[STAGES-1];
  end
endmodule

// File: rtl/i2cm_qtimer.sv
module i2cm_qtimer #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             stall,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = run && !stall && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else if (!stall)        cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/i2cm_shift.sv
module i2cm_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load)     q <= load_val;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
  import i2cm_pkg::*;
#(
  parameter int DIV_W       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_quarter,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              cmd_nack,
  output logic              done,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ack_received,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

  seq_st_e          st;
  cmd_op_e          op;
  logic [1:0]       q_idx;
  logic [BIT_W-1:0] bitn;
  logic [BIT_W-1:0] nb;
  logic             rd_mode;
  logic             nack_lvl;
  logic             nb_level;
  logic             accept;
  logic             tick;
  logic             stall;
  logic             scl_s;
  logic             sda_s;
  logic [1:0]       line_s;
  logic             shift_en;
  logic             sh_load;
  logic [BYTE_W-1:0] sh_q;

  assign op        = cmd_op_e'(cmd_op);
  assign cmd_ready = (st == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign scl_s     = line_s[1];
  assign sda_s     = line_s[0];
  // clock line released but still read low: a target is stretching
  assign stall     = (q_idx == 2'd1) && !scl_s;

  i2cm_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s)
  );

  i2cm_qtimer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st != ST_IDLE), .stall(stall),
    .div(div_quarter), .tick(tick)
  );

  assign sh_load  = accept && (op == OP_WRITE || op == OP_READ);
  assign shift_en = tick && (st == ST_BYTE) && (q_idx == 2'd1) && (bitn < LAST_BIT);

  i2cm_shift #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load),
    .load_val((op == OP_READ) ? {BYTE_W{1'b1}} : cmd_wdata),
    .shift_en(shift_en), .din(sda_s), .q(sh_q)
  );
  assign rx_data = sh_q;

  // level wanted on SDA for the bit after the current one
  assign nb = bitn + BIT_W'(1);
  always_comb begin
    if (nb < LAST_BIT) nb_level = rd_mode ? 1'b1 : sh_q[BYTE_W-1];
    else               nb_level = rd_mode ? nack_lvl : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      q_idx        <= 2'd0;
      bitn         <= '0;
      rd_mode      <= 1'b0;
      nack_lvl     <= 1'b0;
      scl_oe       <= 1'b0;
      sda_oe       <= 1'b0;
      done         <= 1'b0;
      ack_received <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_IDLE) begin
        if (accept) begin
          q_idx <= 2'd0;
          bitn  <= '0;
          unique case (op)
            OP_START: begin st <= ST_START; sda_oe <= 1'b0; end
            OP_WRITE: begin
              st <= ST_BYTE; rd_mode <= 1'b0;
              sda_oe <= !cmd_wdata[BYTE_W-1];
            end
            OP_READ: begin
              st <= ST_BYTE; rd_mode <= 1'b1; nack_lvl <= cmd_nack;
              sda_oe <= 1'b0;
            end
            OP_STOP: begin st <= ST_STOP; sda_oe <= 1'b1; end
          endcase
        end
      end else if (tick) begin
        unique case (q_idx)
          2'd0: begin q_idx <= 2'd1; scl_oe <= 1'b0; end
          2'd1: begin
            q_idx <= 2'd2;
            if (st == ST_START)      sda_oe <= 1'b1;
            else if (st == ST_STOP)  sda_oe <= 1'b0;
            else if (bitn == LAST_BIT) ack_received <= !sda_s;
          end
          2'd2: begin
            q_idx <= 2'd3;
            if (st != ST_STOP) scl_oe <= 1'b1;
          end
          2'd3: begin
            if (st == ST_BYTE && bitn != LAST_BIT) begin
              bitn   <= nb;
              q_idx  <= 2'd0;
              sda_oe <= !nb_level;
            end else begin
              st    <= ST_IDLE;
              q_idx <= 2'd0;
              done  <= 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R3
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (st == ST_START || st == ST_STOP))
    else $error("SDA moved under a released SCL outside START/STOP");

  // R8
  stretch_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && q_idx == 2'd1 && !scl_s) |=> (q_idx == 2'd1 && !scl_oe))
    else $error("advanced while the clock line was held low");

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready)
    else $error("ready stayed high after a command was taken");

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done lasted more than one cycle");

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(st == ST_STOP)) |-> (!scl_oe && !sda_oe))
    else $error("lines not released after STOP");
endmodule

// File: tb/i2cm_master_tb.sv
module i2cm_master_tb;
  import i2cm_pkg::*;

  localparam logic [6:0] TADDR = 7'h2C;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic [11:0] div_q;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [7:0]  cmd_wdata;
  logic        cmd_nack;
  logic        done;
  logic [7:0]  rx_data;
  logic        ack_received;
  logic        scl_oe, sda_oe;
  logic        scl_line, sda_line;
  logic        tgt_scl_pull, tgt_sda_pull;

  assign scl_line = !(scl_oe || tgt_scl_pull);
  assign sda_line = !(sda_oe || tgt_sda_pull);

  i2cm_master u_dut (
    .clk(clk), .rst_n(rst_n), .div_quarter(div_q),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack), .done(done),
    .rx_data(rx_data), .ack_received(ack_received),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_val(input int i);
    return 8'hC3 ^ 8'(i * 53);
  endfunction

  function automatic logic [7:0] wpat(input int i);
    logic [7:0] b;
    b = 8'h80 >> i;
    return i[0] ? ~b : b;
  endfunction

  // ---------------- behavioural target on the wired-AND lines -------------
  bit         sl_prev = 1'b1, sd_prev = 1'b1;
  bit         busy = 0, phase_addr = 0, sel = 0, rw = 0, reading = 0, mack_ok = 0;
  bit         hi_meas = 0, lo_meas = 0;
  int         bitpos = 0, wcnt = 0, rcnt = 0, macnt = 0, nack_at = -1;
  int         nstarts = 0, nstops = 0, stretch_len = 0, st_cnt = 0;
  int         hi_cnt = 0, lo_cnt = 0, hi_bad = 0, lo_bad = 0, lo_max = 0;
  logic [7:0] rxb = 8'h00, txb = 8'h00;
  logic [7:0] wlog [0:15];
  bit         mack [0:15];

  assign tgt_scl_pull = (st_cnt != 0);

  always @(posedge clk) begin
    if (!rst_n) begin
      tgt_sda_pull <= 1'b0;
      st_cnt       <= 0;
      sl_prev = 1'b1; sd_prev = 1'b1; busy = 0; bitpos = 0;
    end else begin
      bit rise, fall;
      rise = !sl_prev && scl_line;
      fall = sl_prev && !scl_line;
      if (sl_prev && scl_line && sd_prev && !sda_line) begin
        nstarts++; busy = 1; bitpos = 0; phase_addr = 1; reading = 0;
        wcnt = 0; rcnt = 0; macnt = 0; tgt_sda_pull <= 1'b0;
      end else if (sl_prev && scl_line && !sd_prev && sda_line) begin
        nstops++; busy = 0; reading = 0; hi_meas = 0; tgt_sda_pull <= 1'b0;
      end
      if (rise) begin
        if (lo_meas && lo_cnt < 2 * int'(div_q)) lo_bad++;
        if (lo_meas && lo_cnt > lo_max) lo_max = lo_cnt;
        lo_meas = 0; hi_cnt = 1; hi_meas = busy;
        if (bitpos < 8) rxb = {rxb[6:0], sda_line};
        else if (reading) begin
          mack_ok = !sda_line; mack[macnt] = !sda_line; macnt++;
        end
        bitpos++;
      end else if (scl_line) hi_cnt++;
      if (fall) begin
        if (hi_meas && (hi_cnt < 2 * int'(div_q) || hi_cnt > 2 * int'(div_q) + 4)) hi_bad++;
        hi_meas = 0; lo_cnt = 1; lo_meas = busy;
        if (bitpos == 8) begin
          if (phase_addr) begin
            sel = (rxb[7:1] == TADDR); rw = rxb[0];
            tgt_sda_pull <= sel;
          end else if (sel && !reading) begin
            wlog[wcnt] = rxb;
            tgt_sda_pull <= (wcnt != nack_at);
            wcnt++;
          end else tgt_sda_pull <= 1'b0;
        end else if (bitpos == 9) begin
          bitpos = 0;
          tgt_sda_pull <= 1'b0;
          if (phase_addr) begin
            phase_addr = 0;
            reading = sel && rw;
            if (reading) begin txb = rd_val(rcnt); rcnt++; tgt_sda_pull <= !txb[7]; end
          end else if (reading) begin
            if (mack_ok) begin txb = rd_val(rcnt); rcnt++; tgt_sda_pull <= !txb[7]; end
            else reading = 0;
          end
        end else if (reading && bitpos >= 1 && bitpos <= 7) begin
          tgt_sda_pull <= !txb[7 - bitpos];
        end
      end else if (!scl_line) lo_cnt++;
      if (fall && stretch_len > 0) st_cnt <= stretch_len;
      else if (st_cnt > 0)         st_cnt <= st_cnt - 1;
      sl_prev = scl_line;
      sd_prev = sda_line;
    end
  end

  // ---------------- command driver ----------------
  logic [7:0] got_rx;
  logic       got_ack;
  task automatic do_cmd(input cmd_op_e op, input logic [7:0] wd, input logic nk);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_nack = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    got_rx = rx_data; got_ack = ack_received;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R9 watchdog actual=hung expected=complete");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int s0, p0, bad;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_wdata = 8'h00;
    cmd_nack = 1'b0; div_q = 12'd3;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(done == 1'b0, "R1 done low after reset", done, 0);

    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 2; s++) begin
        div_q = (d == 0) ? 12'd3 : 12'd6;
        stretch_len = (s == 0) ? 0 : 25;
        hi_bad = 0; lo_bad = 0; lo_max = 0; nack_at = -1;

        // write transfer, walking patterns
        s0 = nstarts; p0 = nstops;
        do_cmd(OP_START, 8'h00, 1'b0);
        do_cmd(OP_WRITE, {TADDR, 1'b0}, 1'b0);
        chk(got_ack == 1'b1, "R4 address acknowledged", got_ack, 1);
        chk(got_rx == {TADDR, 1'b0}, "R4 line readback of address", got_rx, {TADDR, 1'b0});
        for (int i = 0; i < 8; i++) begin
          do_cmd(OP_WRITE, wpat(i), 1'b0);
          chk(got_ack == 1'b1, "R4 data acknowledged", got_ack, 1);
        end
        do_cmd(OP_STOP, 8'h00, 1'b0);
        for (int i = 0; i < 8; i++)
          chk(wlog[i] == wpat(i), "R4 target received byte MSB first", wlog[i], wpat(i));
        chk(nstarts == s0 + 1, "R2 one start event", nstarts - s0, 1);
        chk(nstops == p0 + 1, "R6 one stop event", nstops - p0, 1);
        chk(!scl_oe && !sda_oe && scl_line && sda_line, "R6 bus idle after STOP",
            {scl_line, sda_line}, 3);

        // write pointer, repeated START, read three bytes
        s0 = nstarts; p0 = nstops;
        do_cmd(OP_START, 8'h00, 1'b0);
        do_cmd(OP_WRITE, {TADDR, 1'b0}, 1'b0);
        do_cmd(OP_WRITE, 8'h10, 1'b0);
        do_cmd(OP_START, 8'h00, 1'b0);
        do_cmd(OP_WRITE, {TADDR, 1'b1}, 1'b0);
        chk(got_ack == 1'b1, "R2 read address acked after repeated START", got_ack, 1);
        for (int i = 0; i < 3; i++) begin
          do_cmd(OP_READ, 8'h00, (i == 2));
          chk(got_rx == rd_val(i), "R5 read byte MSB first", got_rx, rd_val(i));
        end
        do_cmd(OP_STOP, 8'h00, 1'b0);
        chk(macnt == 3, "R5 target saw three ack clocks", macnt, 3);
        chk(mack[0] && mack[1] && !mack[2], "R5 ack,ack,nack from master",
            {mack[0], mack[1], mack[2]}, 3'b110);
        chk(nstarts == s0 + 2 && nstops == p0 + 1, "R3 no stray start or stop",
            (nstarts - s0) * 16 + (nstops - p0), 8'h21);

        // not-acknowledge handling
        do_cmd(OP_START, 8'h00, 1'b0);
        do_cmd(OP_WRITE, {7'h2D, 1'b0}, 1'b0);
        chk(got_ack == 1'b0, "R10 unknown address reported as NACK", got_ack, 0);
        nack_at = 1;
        do_cmd(OP_START, 8'h00, 1'b0);
        do_cmd(OP_WRITE, {TADDR, 1'b0}, 1'b0);
        chk(got_ack == 1'b1, "R10 address acked after repeated START", got_ack, 1);
        do_cmd(OP_WRITE, 8'h5A, 1'b0);
        chk(got_ack == 1'b1, "R10 first data acked", got_ack, 1);
        do_cmd(OP_WRITE, 8'hA5, 1'b0);
        chk(got_ack == 1'b0, "R10 refused data reported as NACK", got_ack, 0);
        p0 = nstops;
        do_cmd(OP_STOP, 8'h00, 1'b0);
        chk(nstops == p0 + 1, "R10 STOP after NACK", nstops - p0, 1);

        chk(hi_bad == 0, "R7 SCL high phase width", hi_bad, 0);
        chk(lo_bad == 0, "R7 SCL low phase width", lo_bad, 0);
        if (stretch_len > 0)
          chk(lo_max >= stretch_len, "R8 stretched low honoured", lo_max, stretch_len);
      end
    end

    // R9 handshake: a held command during a running one is not taken
    div_q = 12'd3; stretch_len = 0;
    do_cmd(OP_START, 8'h00, 1'b0);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = OP_WRITE; cmd_wdata = {TADDR, 1'b0};
    @(negedge clk);
    cmd_op = OP_STOP;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      if (cmd_ready) bad++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(bad == 0, "R9 ready low while busy", bad, 0);
    chk(ack_received == 1'b1, "R9 running command unaffected", ack_received, 1);
    p0 = nstops;
    do_cmd(OP_STOP, 8'h00, 1'b0);
    chk(nstops == p0 + 1, "R9 held command was not taken", nstops - p0, 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule